// File: doc/BRIEF.md
# Pre-Trigger Circular Capture Controller

This controller steers an oscilloscope-style acquisition into a circular sample buffer whose depth is a power of two. A rising edge on the run input arms a capture. The controller first stores a programmed number of samples that precede the trigger, and it ignores the trigger while it does so. It then writes continuously, wrapping around the buffer, until the trigger flag arrives. After the trigger it stores exactly the number of further samples that completes the programmed total, and then it stops.

The block does not contain the sample memory. It drives the memory's write strobe, write address and write data, and it passes the incoming stream data straight through. Software reads a status word to locate the capture. Bit 0 of that word is a busy flag, and the bits above bit 0 hold the next write position. Both lengths are programmed as the count minus one. For example, a pre-trigger value of 1023 gives 1024 samples.

Top module: `pretrig_capture`

## Requirements
- R1: After reset the controller is idle, status_o is all zeros, and wr_en_o stays 0 even when stream data is valid.
- R2: A capture starts only on a 0-to-1 transition of run_i. Holding run_i high does not start a second capture, and status_o[0] reads 1 from the cycle after the transition.
- R3: After a start, the first N valid samples, where N = pre_len_i+1 as captured at the start, go to addresses 0 to N-1. Any trig_i pulse during this phase is discarded.
- R4: wr_en_o is 1 exactly when s_valid_i is 1 and a capture is in progress. wr_data_o equals s_data_i.
- R5: Once the pre-trigger phase is complete, the first cycle with trig_i high ends the wait. Exactly M-N further valid samples are then written, where M = total_len_i+1, and status_o[0] then returns to 0.
- R6: The write address starts at 0 on each start and advances by one per written sample, modulo M.
- R7: status_o[0] is the busy flag, and status_o[ADDR_W:1] is the address the next sample will be written to.
- R8: A rising edge on run_i while a capture is in progress is ignored. The address and the phase continue undisturbed.
- R9: A trig_i pulse that arrives in the same cycle as the final pre-trigger sample is discarded.
- R10: When N equals M, the trigger ends the capture at once, and no post-trigger sample is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Run level; its rising edge starts a capture |
| trig_i | input | 1 | Trigger flag |
| pre_len_i | input | ADDR_W | Pre-trigger sample count minus one |
| total_len_i | input | ADDR_W | Total sample count minus one (2^k - 1) |
| s_valid_i | input | 1 | Stream sample valid |
| s_data_i | input | DATA_W | Stream sample data |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | ADDR_W | Buffer write address |
| wr_data_o | output | DATA_W | Buffer write data |
| status_o | output | ADDR_W+1 | {next write address, busy} |

## Verification
The trigger can arrive in the same cycle as the last pre-trigger sample. In that cycle the controller completes the pre-trigger phase, but it must not accept the trigger. The bench creates this case on purpose: it holds trig_i high through the entire pre-trigger phase, including its final valid sample. It then checks two things. The controller must still be waiting afterwards, and the post-trigger count must begin only from a later trigger. The random phase also produces starts that coincide with ongoing captures and triggers that coincide with valid samples. Every such cycle is compared against a requirement-level model.

// File: rtl/pc_pkg.sv
package pc_pkg;
   typedef enum logic [1:0] {
      PC_IDLE  = 2'd0,
      PC_PRE   = 2'd1,
      PC_ARMED = 2'd2,
      PC_POST  = 2'd3
   } pc_state_t;
endpackage

// File: rtl/pc_rise_det.sv
module pc_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;

   // R2: a held level yields a single-cycle pulse
   p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/pc_wr_addr.sv
module pc_wr_addr #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              adv_i,
   input  logic [ADDR_W-1:0] mask_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       addr_q <= '0;
      else if (clear_i) addr_q <= '0;
      else if (adv_i)   addr_q <= (addr_q + 1'b1) & mask_i;
   end

   assign addr_o = addr_q;

   // R6: the last slot of the buffer is followed by slot zero
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !clear_i && addr_q == mask_i) |=> addr_q == '0);
   // R6: a start clears the position
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> addr_q == '0);
endmodule

// File: rtl/pc_fsm.sv
module pc_fsm
   import pc_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              trig_i,
   input  logic              valid_i,
   input  logic [ADDR_W-1:0] pre_len_i,
   input  logic [ADDR_W-1:0] total_len_i,
   output pc_state_t         state_o,
   output logic              clear_o,
   output logic [ADDR_W-1:0] mask_o
);
   pc_state_t         state_q;
   logic [ADDR_W-1:0] cnt_q;
   logic [ADDR_W-1:0] left_q;
   logic [ADDR_W-1:0] pre_q;
   logic [ADDR_W-1:0] tot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PC_IDLE;
         cnt_q   <= '0;
         left_q  <= '0;
         pre_q   <= '0;
         tot_q   <= '0;
      end else begin
         unique case (state_q)
            PC_IDLE: begin
               if (start_i) begin
                  state_q <= PC_PRE;
                  cnt_q   <= '0;
                  pre_q   <= pre_len_i;
                  tot_q   <= total_len_i;
               end
            end
            PC_PRE: begin
               if (valid_i) begin
                  if (cnt_q == pre_q) state_q <= PC_ARMED;
                  else                cnt_q   <= cnt_q + 1'b1;
               end
            end
            PC_ARMED: begin
               if (trig_i) begin
                  if (tot_q == pre_q) state_q <= PC_IDLE;
                  else begin
                     state_q <= PC_POST;
                     left_q  <= tot_q - pre_q;
                  end
               end
            end
            PC_POST: begin
               if (valid_i) begin
                  if (left_q == 1) state_q <= PC_IDLE;
                  left_q <= left_q - 1'b1;
               end
            end
            default: state_q <= PC_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign clear_o = (state_q == PC_IDLE) && start_i;
   assign mask_o  = tot_q;

   // R3 and R9: the trigger has no effect before the pre-trigger phase is complete
   p_pre_ignores_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PC_PRE && !(valid_i && cnt_q == pre_q)) |=> state_q == PC_PRE);
   p_last_pre_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PC_PRE && valid_i && cnt_q == pre_q) |=> state_q == PC_ARMED);
   // R8: a start while waiting for the trigger changes nothing
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PC_ARMED && start_i && !trig_i) |=> state_q == PC_ARMED);
   // R5: the post-trigger phase never runs with nothing left to write
   p_post_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == PC_POST |-> left_q != '0);
   // R10: a full pre-trigger fill ends at the trigger
   p_full_pre_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PC_ARMED && trig_i && tot_q == pre_q) |=> state_q == PC_IDLE);
endmodule

// File: rtl/pretrig_capture.sv
module pretrig_capture
   import pc_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              trig_i,
   input  logic [ADDR_W-1:0] pre_len_i,
   input  logic [ADDR_W-1:0] total_len_i,
   input  logic              s_valid_i,
   input  logic [DATA_W-1:0] s_data_i,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [ADDR_W:0]   status_o
);
   localparam int STAT_W = ADDR_W + 1;

   generate
      if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr_w
         $error("pretrig_capture: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("pretrig_capture: DATA_W must be positive");
      end
   endgenerate

   logic              start;
   logic              clear;
   logic              busy;
   logic              adv;
   logic [ADDR_W-1:0] mask;
   logic [ADDR_W-1:0] addr;
   pc_state_t         state;

   pc_rise_det u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (run_i),
      .rise_o (start)
   );

   pc_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .trig_i      (trig_i),
      .valid_i     (s_valid_i),
      .pre_len_i   (pre_len_i),
      .total_len_i (total_len_i),
      .state_o     (state),
      .clear_o     (clear),
      .mask_o      (mask)
   );

   assign busy = (state != PC_IDLE);
   assign adv  = s_valid_i && busy;

   pc_wr_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .adv_i   (adv),
      .mask_i  (mask),
      .addr_o  (addr)
   );

   assign wr_en_o   = adv;
   assign wr_addr_o = addr;
   assign wr_data_o = s_data_i;
   assign status_o  = STAT_W'({addr, busy});

   // R4: no write outside a capture or without valid data
   p_wr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (s_valid_i && status_o[0]));
   // R7: the reported position matches the address used for writing
   p_status_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[ADDR_W:1] == wr_addr_o);
   // R2: a rising run edge while idle makes the block busy
   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!status_o[0] && run_i && !$past(run_i)) |=> status_o[0]);
   // R5: the busy flag only drops after a write or on the trigger
   p_stop_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_o[0]) |-> ($past(wr_en_o) || $past(trig_i)));
endmodule

// File: tb/pretrig_capture_tb.sv
module pretrig_capture_tb;
   localparam int AW = 10;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run_i = 1'b0;
   logic          trig_i = 1'b0;
   logic [AW-1:0] pre_len_i = '0;
   logic [AW-1:0] total_len_i = '0;
   logic          s_valid_i = 1'b0;
   logic [DW-1:0] s_data_i = '0;
   logic          wr_en_o;
   logic [AW-1:0] wr_addr_o;
   logic [DW-1:0] wr_data_o;
   logic [AW:0]   status_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // model of the requirements
   int          m_state = 0;   // 0 idle, 1 pre, 2 waiting, 3 post
   logic [AW-1:0] m_addr = '0, m_cnt = '0, m_left = '0, m_pre = '0, m_tot = '0;
   logic        m_runq = 1'b0;
   logic        obs_en;
   logic [AW:0] obs_stat;

   always #5 clk = ~clk;

   pretrig_capture #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .trig_i(trig_i),
      .pre_len_i(pre_len_i), .total_len_i(total_len_i),
      .s_valid_i(s_valid_i), .s_data_i(s_data_i),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .status_o(status_o));

   task automatic check(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [AW-1:0] m);
      return (a + 1'b1) & m;
   endfunction

   task automatic step(input logic run, input logic trg, input logic vld, input logic [DW-1:0] dat);
      logic rise;
      @(negedge clk);
      run_i = run; trig_i = trg; s_valid_i = vld; s_data_i = dat;
      #1;
      obs_en = wr_en_o; obs_stat = status_o;
      check("R4 wr_en", wr_en_o, (vld && m_state != 0));
      if (wr_en_o) begin
         check("R6 wr_addr", wr_addr_o, m_addr);
         check("R4 wr_data", wr_data_o, dat);
      end
      check("R7 status", status_o, {m_addr, (m_state != 0)});
      rise = run && !m_runq;
      m_runq = run;
      case (m_state)
         0: if (rise) begin m_state = 1; m_addr = '0; m_cnt = '0;
                            m_pre = pre_len_i; m_tot = total_len_i; end
         1: if (vld) begin
               m_addr = nxt(m_addr, m_tot);
               if (m_cnt == m_pre) m_state = 2; else m_cnt = m_cnt + 1'b1;
            end
         2: begin
               if (vld) m_addr = nxt(m_addr, m_tot);
               if (trg) begin
                  if (m_tot == m_pre) m_state = 0;
                  else begin m_state = 3; m_left = m_tot - m_pre; end
               end
            end
         default: if (vld) begin
               m_addr = nxt(m_addr, m_tot);
               if (m_left == 1) m_state = 0;
               m_left = m_left - 1'b1;
            end
      endcase
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int wcount;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      step(0, 0, 1, 16'h1234);
      check("R1 status after reset", obs_stat, 0);
      check("R1 wr_en after reset", obs_en, 0);

      // directed: N=4, M=16; triggers throughout pre phase (R3, R9), start while busy (R8)
      pre_len_i = 10'd3; total_len_i = 10'd15;
      step(1, 0, 0, 0);
      step(1, 0, 0, 0);
      check("R2 busy after rise", obs_stat[0], 1);
      step(1, 0, 0, 0);
      step(0, 0, 0, 0);
      for (int i = 0; i < 4; i++) step(0, 1, 1, 16'(100 + i));   // last one coincides (R9)
      step(0, 0, 0, 0);
      check("R3 pre fill position", obs_stat[AW:1], 4);
      check("R9 still waiting after coincident trigger", obs_stat[0], 1);
      step(1, 0, 1, 16'h55);                                     // R8: start while busy
      step(0, 0, 0, 0);
      check("R8 position kept", obs_stat[AW:1], 5);
      step(0, 1, 1, 16'h77);                                     // trigger accepted
      wcount = 0;
      for (int i = 0; i < 40; i++) begin
         step(0, 0, 1, 16'(i));
         if (obs_stat[0] && obs_en) wcount++;
      end
      check("R5 post-trigger writes", wcount, 12);
      check("R5 idle after capture", obs_stat[0], 0);

      // R10: N equals M
      pre_len_i = 10'd7; total_len_i = 10'd7;
      step(1, 0, 0, 0);
      for (int i = 0; i < 8; i++) step(0, 0, 1, 16'(i));
      step(0, 1, 0, 0);
      step(0, 0, 1, 0);
      check("R10 idle right after trigger", obs_stat[0], 0);
      check("R10 no extra write", obs_en, 0);

      // R6: wrap with M=4
      pre_len_i = 10'd1; total_len_i = 10'd3;
      step(1, 0, 0, 0);
      for (int i = 0; i < 6; i++) step(0, 0, 1, 16'(i));
      step(0, 0, 0, 0);
      check("R6 wrapped position", obs_stat[AW:1], 2);
      step(0, 1, 0, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 1, 0);

      // random phase checked against the model
      for (int i = 0; i < 6000; i++) begin
         if (m_state == 0 && ($urandom % 8) == 0) begin
            int k = 1 + ($urandom % 6);
            total_len_i = AW'((1 << k) - 1);
            pre_len_i   = AW'($urandom % (1 << k));
         end
         step(($urandom % 6) == 0, ($urandom % 10) == 0,
              ($urandom % 4) != 0, 16'($urandom));
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule